// File: doc/BRIEF.md
# Embedded-Sync Video Timing Generator

This block is the timing master for an 8-bit component video stream with embedded synchronisation. From the pixel clock and a select input that chooses between 525-line/60 Hz and 625-line/50 Hz operation, it keeps a clock-within-line counter and a line counter. From these it derives the horizontal, field and vertical-blanking flags of the current position.

It emits an 8-bit stream template on every clock. The template carries the four-byte end-of-active and start-of-active timing codes with their protection bits and an alternating blanking fill. It also raises a request strobe during the active samples of picture lines; while the strobe is high, the byte offered on the pixel input goes straight to the output in the same cycle. The horizontal flag appears on a horizontal-sync pin and the field flag on a vertical-sync pin. Both pins are driven by the same counters that produce the embedded codes.

A synchronous reset places the generator at clock 0 of line 1 and loads the standard immediately. After that, a change on the select input is only adopted when one frame ends and the next begins.

Top module: `sdv_timing_gen`

## Requirements
- R1: A line lasts 8 + B + A clocks, where A = 1440 active clocks and B = 268 blanking clocks (525-line mode) or 280 (625-line mode). This gives 1716 and 1728 clocks. Lines are counted 1 to 525 or 1 to 625, then wrap to 1.
- R2: Clocks 0–3 of a line carry the end-of-active code and clocks 4+B to 7+B carry the start-of-active code. Each code is the byte sequence FF, 00, 00, then a status byte.
- R3: The status byte is {1, F, V, H, V^H, F^H, F^V, F^V^H} from bit 7 down to bit 0. H is 1 in the end-of-active code and 0 in the start-of-active code.
- R4: On a blanking clock at line position n, data_o is 8'h80 if n is even and 8'h10 if n is odd.
- R5: hsync_o is 1 from clock 0 up to and including the last blanking clock (3+B). It is 0 during the start-of-active code and the active clocks.
- R6: In 525-line mode, vsync_o (the F flag) is 1 on lines 266–525 and 1–3, and 0 on other lines.
- R7: In 625-line mode, vsync_o is 1 on lines 313–625 and 0 on lines 1–312.
- R8: V is 1 on lines 1–19 and 264–282 in 525-line mode, and on lines 1–22, 311–335 and 624–625 in 625-line mode. On those lines the active clocks carry the blanking fill of R4 and req_o stays 0.
- R9: On lines with V = 0, req_o is 1 for exactly the A clocks after the start-of-active code. In those cycles data_o equals pix_i in the same cycle.
- R10: While rst_i is sampled high, the generator sits at clock 0 of line 1 and adopts std625_i at once. Counting resumes from there on the first edge with rst_i low.
- R11: When std625_i changes mid-frame, the line length and flag pattern of the old standard continue to the end of the current frame. The new standard applies from line 1 of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_i | input | 1 | Synchronous reset, active high |
| std625_i | input | 1 | Standard select: 0 = 525 lines, 1 = 625 lines |
| pix_i | input | 8 | Active sample from the pixel source, used while req_o is high |
| data_o | output | 8 | Stream template with codes, fill and active samples |
| hsync_o | output | 1 | Horizontal flag H |
| vsync_o | output | 1 | Field flag F |
| req_o | output | 1 | Active-sample request strobe |

## Verification
The delicate coincidence is a standard switch landing on the same clock as the last clock of a frame. In that cycle the clock counter wraps, the line counter returns to 1, and the line length and flag tables all swap together. The bench provokes it by changing the select input in the middle of a frame, with the line length scaled down so that whole frames fit the run. It judges the result with a per-cycle reference model that keeps the old standard until its own frame wrap, and with a separate line-period measurement taken between rising edges of hsync_o. A reset raised in the middle of a line with a new standard pending provokes the second path into the same state, and is judged the same way.

// File: rtl/sdv_pkg.sv
package sdv_pkg;

  localparam int unsigned LINE_W = 10;

  // number of lines in a frame for the selected standard
  function automatic logic [LINE_W-1:0] frame_lines(input logic is625);
    return is625 ? LINE_W'(625) : LINE_W'(525);
  endfunction

  // field flag for a line number (lines count from 1)
  function automatic logic field_bit(input logic is625, input logic [LINE_W-1:0] ln);
    if (is625) return (ln >= LINE_W'(313));
    return (ln >= LINE_W'(266)) || (ln <= LINE_W'(3));
  endfunction

  // vertical blanking flag for a line number
  function automatic logic vblank_bit(input logic is625, input logic [LINE_W-1:0] ln);
    if (is625)
      return (ln <= LINE_W'(22)) || (ln >= LINE_W'(311) && ln <= LINE_W'(335)) ||
             (ln >= LINE_W'(624));
    return (ln <= LINE_W'(19)) || (ln >= LINE_W'(264) && ln <= LINE_W'(282));
  endfunction

  // status byte of a timing code with its protection bits
  function automatic logic [7:0] code_word(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/sdv_hcount.sv
module sdv_hcount #(
  parameter int ACT_CLKS  = 1440,
  parameter int BLANK_525 = 268,
  parameter int BLANK_625 = 280,
  parameter int HW        = 11
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          is625_i,
  output logic [HW-1:0] hcnt_o,
  output logic          line_end_o
);
  localparam int TOT_525 = 8 + BLANK_525 + ACT_CLKS;
  localparam int TOT_625 = 8 + BLANK_625 + ACT_CLKS;

  logic [HW-1:0] last_pos;

  assign last_pos   = is625_i ? HW'(TOT_625 - 1) : HW'(TOT_525 - 1);
  assign line_end_o = (hcnt_o == last_pos);

  always_ff @(posedge clk_i) begin
    if (rst_i)           hcnt_o <= '0;
    else if (line_end_o) hcnt_o <= '0;
    else                 hcnt_o <= hcnt_o + HW'(1);
  end

  assert_hwrap_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    line_end_o |=> (hcnt_o == '0));

  assert_hrange_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    hcnt_o <= last_pos);

endmodule

// File: rtl/sdv_vcount.sv
module sdv_vcount
  import sdv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              line_end_i,
  input  logic              std625_i,
  output logic              is625_o,
  output logic [LINE_W-1:0] line_o,
  output logic              f_o,
  output logic              v_o,
  output logic              frame_end_o
);
  logic [LINE_W-1:0] last_line;

  assign last_line   = frame_lines(is625_o);
  assign frame_end_o = line_end_i && (line_o == last_line);
  assign f_o         = field_bit(is625_o, line_o);
  assign v_o         = vblank_bit(is625_o, line_o);

  always_ff @(posedge clk_i) begin
    if (rst_i || frame_end_o) begin
      line_o  <= LINE_W'(1);
      is625_o <= std625_i;
    end else if (line_end_i) begin
      line_o  <= line_o + LINE_W'(1);
    end
  end

  assert_std_hold_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    !frame_end_o |=> $stable(is625_o));

  assert_frame_wrap_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    frame_end_o |=> (line_o == LINE_W'(1)));

  assert_line_range_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (line_o >= LINE_W'(1)) && (line_o <= last_line));

endmodule

// File: rtl/sdv_stream.sv
module sdv_stream
  import sdv_pkg::*;
#(
  parameter int BLANK_525 = 268,
  parameter int BLANK_625 = 280,
  parameter int HW        = 11
) (
  input  logic [HW-1:0] hcnt_i,
  input  logic          is625_i,
  input  logic          f_i,
  input  logic          v_i,
  input  logic [7:0]    pix_i,
  output logic [7:0]    data_o,
  output logic          hflag_o,
  output logic          req_o,
  output logic [HW-1:0] sav_pos_o,
  output logic [HW-1:0] act_pos_o
);
  logic in_eav, in_sav, in_act;
  logic [1:0] phase;

  assign sav_pos_o = is625_i ? HW'(4 + BLANK_625) : HW'(4 + BLANK_525);
  assign act_pos_o = is625_i ? HW'(8 + BLANK_625) : HW'(8 + BLANK_525);

  assign in_eav  = (hcnt_i < HW'(4));
  assign in_sav  = (hcnt_i >= sav_pos_o) && (hcnt_i < act_pos_o);
  assign in_act  = (hcnt_i >= act_pos_o);
  assign hflag_o = (hcnt_i < sav_pos_o);
  assign req_o   = in_act && !v_i;
  assign phase   = in_eav ? hcnt_i[1:0] : 2'(hcnt_i - sav_pos_o);

  always_comb begin
    if (in_eav || in_sav) begin
      case (phase)
        2'd0:    data_o = 8'hFF;
        2'd1,
        2'd2:    data_o = 8'h00;
        default: data_o = code_word(f_i, v_i, in_eav);
      endcase
    end else if (req_o) begin
      data_o = pix_i;
    end else begin
      data_o = hcnt_i[0] ? 8'h10 : 8'h80;
    end
  end

endmodule

// File: rtl/sdv_timing_gen.sv
module sdv_timing_gen
  import sdv_pkg::*;
#(
  parameter int ACT_CLKS  = 1440,
  parameter int BLANK_525 = 268,
  parameter int BLANK_625 = 280
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       std625_i,
  input  logic [7:0] pix_i,
  output logic [7:0] data_o,
  output logic       hsync_o,
  output logic       vsync_o,
  output logic       req_o
);
  localparam int BLANK_MAX = (BLANK_625 > BLANK_525) ? BLANK_625 : BLANK_525;
  localparam int TOT_MAX   = 8 + BLANK_MAX + ACT_CLKS;
  localparam int HW        = $clog2(TOT_MAX);

  logic [HW-1:0]     hcnt_w;
  logic              line_end_w;
  logic              is625_w;
  logic [LINE_W-1:0] line_w;
  logic              f_w, v_w, frame_end_w;
  logic [HW-1:0]     sav_pos_w, act_pos_w;

  sdv_hcount #(
    .ACT_CLKS(ACT_CLKS), .BLANK_525(BLANK_525), .BLANK_625(BLANK_625), .HW(HW)
  ) u_hcount (
    .clk_i(clk_i), .rst_i(rst_i), .is625_i(is625_w),
    .hcnt_o(hcnt_w), .line_end_o(line_end_w)
  );

  sdv_vcount u_vcount (
    .clk_i(clk_i), .rst_i(rst_i), .line_end_i(line_end_w), .std625_i(std625_i),
    .is625_o(is625_w), .line_o(line_w), .f_o(f_w), .v_o(v_w),
    .frame_end_o(frame_end_w)
  );

  sdv_stream #(
    .BLANK_525(BLANK_525), .BLANK_625(BLANK_625), .HW(HW)
  ) u_stream (
    .hcnt_i(hcnt_w), .is625_i(is625_w), .f_i(f_w), .v_i(v_w), .pix_i(pix_i),
    .data_o(data_o), .hflag_o(hsync_o), .req_o(req_o),
    .sav_pos_o(sav_pos_w), .act_pos_o(act_pos_w)
  );

  assign vsync_o = f_w;

  // request only opens at the first active clock of a picture line
  assert_req_open_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(req_o) |-> (hcnt_w == act_pos_w) && !v_w);

  assert_req_vblank_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    req_o |-> !v_w);

  assert_hsync_fall_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(hsync_o) |-> (hcnt_w == sav_pos_w));

  assert_field_edge_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(vsync_o) |-> (hcnt_w == '0));

  assert_std_at_wrap_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(is625_w) |-> (line_w == LINE_W'(1)) && (hcnt_w == '0));

endmodule

// File: tb/sdv_timing_gen_tb.sv
module sdv_timing_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 150000;
  localparam int SM_ACT     = 32;
  localparam int SM_B525    = 12;
  localparam int SM_B625    = 16;

  typedef struct {
    logic [7:0] d;
    logic hs, vs, rq;
    string td, th, tv, tr;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic std_sel = 1'b0;
  logic [7:0] pix = 8'h00;

  logic [7:0] dat_w [2];
  logic hs_w [2];
  logic vs_w [2];
  logic rq_w [2];

  int n_chk = 0;
  int n_bad = 0;
  item_t sb_q[$];

  int  mh [2];
  int  ml [2];
  bit  ms [2];
  bit  mvalid [2];
  int  last_rise [2];
  bit  rise_std [2];
  bit  prev_hs [2];
  int  cyc = 0;
  bit  pix_run = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdv_timing_gen u_dut (
    .clk_i(clk), .rst_i(rst), .std625_i(std_sel), .pix_i(pix),
    .data_o(dat_w[0]), .hsync_o(hs_w[0]), .vsync_o(vs_w[0]), .req_o(rq_w[0])
  );

  sdv_timing_gen #(.ACT_CLKS(SM_ACT), .BLANK_525(SM_B525), .BLANK_625(SM_B625)) u_dut_small (
    .clk_i(clk), .rst_i(rst), .std625_i(std_sel), .pix_i(pix),
    .data_o(dat_w[1]), .hsync_o(hs_w[1]), .vsync_o(vs_w[1]), .req_o(rq_w[1])
  );

  function automatic int blank_of(int k, bit s);
    if (k == 0) return s ? 280 : 268;
    return s ? SM_B625 : SM_B525;
  endfunction

  function automatic int total_of(int k, bit s);
    return blank_of(k, s) + 8 + ((k == 0) ? 1440 : SM_ACT);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // reference: expected outputs at position (h, l) of standard s
  function automatic item_t expect_at(int k, bit s, int h, int l, logic [7:0] p);
    item_t it;
    int bl = blank_of(k, s);
    int sv = bl + 4;
    int a0 = bl + 8;
    bit f, v, hh;
    int ph;
    f = s ? (l > 312) : (l > 265 || l < 4);
    v = s ? (l < 23 || (l > 310 && l < 336) || l > 623) : (l < 20 || (l > 263 && l < 283));
    it.hs = (h < sv);
    it.vs = f;
    it.rq = (h >= a0) && !v;
    it.th = "R5";
    it.tv = s ? "R7" : "R6";
    it.tr = v ? "R8" : "R9";
    if (h < 4 || (h >= sv && h < a0)) begin
      hh = (h < 4);
      ph = hh ? h : h - sv;
      if (ph == 0) it.d = 8'hFF;
      else if (ph < 3) it.d = 8'h00;
      else it.d = 8'h80 | (8'(f) << 6) | (8'(v) << 5) | (8'(hh) << 4) |
                  (8'(v != hh) << 3) | (8'(f != hh) << 2) | (8'(f != v) << 1) | 8'(f ^ v ^ hh);
      it.td = (ph == 3) ? "R3" : "R2";
    end else if (it.rq) begin
      it.d = p;
      it.td = "R9";
    end else begin
      it.d = (h % 2 == 1) ? 8'h10 : 8'h80;
      it.td = (h >= a0) ? "R8" : "R4";
    end
    return it;
  endfunction

  // driver: the reference pushes the expected item for this cycle
  task automatic push_expect(int k);
    item_t it = expect_at(k, ms[k], mh[k], ml[k], pix);
    if (std_sel != ms[k]) begin
      it.td = "R11"; it.th = "R11"; it.tv = "R11"; it.tr = "R11";
    end
    sb_q.push_back(it);
  endtask

  // monitor: pop and compare against the design
  always @(negedge clk) begin
    item_t got;
    cyc++;
    for (int k = 0; k < 2; k++) begin
      if (mvalid[k]) begin
        push_expect(k);
        got = sb_q.pop_front();
        chk(got.td, int'(dat_w[k]), int'(got.d));
        chk(got.th, int'(hs_w[k]), int'(got.hs));
        chk(got.tv, int'(vs_w[k]), int'(got.vs));
        chk(got.tr, int'(rq_w[k]), int'(got.rq));
        // line period between hsync rising edges
        if (hs_w[k] && !prev_hs[k] && !rst) begin
          if (last_rise[k] >= 0) chk("R1", cyc - last_rise[k], total_of(k, rise_std[k]));
          last_rise[k] = cyc;
          rise_std[k]  = ms[k];
        end
      end
      prev_hs[k] = hs_w[k];
      // advance reference to the state after the coming edge
      if (rst) begin
        mh[k] = 0; ml[k] = 1; ms[k] = std_sel; mvalid[k] = 1'b1; last_rise[k] = -1;
      end else if (mvalid[k]) begin
        if (mh[k] == total_of(k, ms[k]) - 1) begin
          mh[k] = 0;
          if (ml[k] == (ms[k] ? 625 : 525)) begin
            ml[k] = 1; ms[k] = std_sel;
          end else ml[k] = ml[k] + 1;
        end else mh[k] = mh[k] + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (pix_run) pix <= #1 8'($urandom);
  end

  task automatic run(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin
      mvalid[k] = 1'b0; last_rise[k] = -1; prev_hs[k] = 1'b0;
      mh[k] = 0; ml[k] = 1; ms[k] = 1'b0; rise_std[k] = 1'b0;
    end
    run(3);
    // reset state: clock 0 of line 1 in 525 mode gives FF, H=1, F=1
    @(negedge clk);
    chk("R10", int'(dat_w[1]), 8'hFF);
    chk("R10", int'(hs_w[1]), 1);
    chk("R10", int'(vs_w[1]), 1);
    chk("R10", int'(rq_w[1]), 0);
    chk("R10", int'(dat_w[0]), 8'hFF);
    run(1);
    rst = 1'b0;
    pix_run = 1'b1;
    run(30000);          // one full 525 frame of the small instance and part of the next
    std_sel = 1'b1;      // pending change mid-frame
    run(40000);          // crosses the frame boundary into 625
    std_sel = 1'b0;
    run(25000);          // crosses the 625 frame boundary back into 525
    run(37);             // land mid-line
    std_sel = 1'b1;
    rst = 1'b1;
    run(2);
    @(negedge clk);
    chk("R10", int'(dat_w[1]), 8'hFF);
    chk("R10", int'(vs_w[1]), 0);   // line 1 of 625 mode has F = 0
    chk("R10", int'(hs_w[0]), 1);
    run(1);
    rst = 1'b0;
    run(4000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WDOG_CYC);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion (R1)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule